// File: doc/BRIEF.md
# Windowed Register File Controller

This block is a register file whose 32 architectural registers are spread over a physical store of shared globals and a circular ring of overlapping windows. A window pointer picks the active window. A per-window occupancy mask records which windows currently hold live data. Two combinational read ports and one write port are addressed by a 5-bit architectural register number. The block maps each number to a physical register through the pointer.

A call strobe moves the active window down by one and a return strobe moves it back up. Neighbouring windows share eight registers, so values placed in the caller's outgoing group show up in the callee's incoming group, and results travel back the same way. A move that would land on an occupied window (call) or an empty one (return) is refused. The refusal is reported on a one-cycle overflow or underflow flag. The block produces only these flags; spilling windows to memory is left to surrounding logic.

Top module: `rwin_regfile`

## Requirements
- R1: After reset the window pointer is 0, the mask has only bit 0 set, both flags are low and every architectural register reads zero.
- R2: Architectural register 0 always reads as zero, and a write to it has no effect.
- R3: Registers 1–7 (index bits [4:3] = 00) are globals: a value written in one window reads back unchanged from every other window.
- R4: A call alone, whose target window (pointer − 1 modulo NWIN) has a clear mask bit, moves the pointer to the target and sets that bit; no flag is raised.
- R5: A return alone, whose target window (pointer + 1 modulo NWIN) has a set mask bit, moves the pointer to the target and clears the bit of the window being left; no flag is raised.
- R6: A call alone whose target window has a set mask bit raises the overflow flag for exactly the next cycle and leaves pointer and mask unchanged.
- R7: A return alone whose target window has a clear mask bit raises the underflow flag for exactly the next cycle and leaves pointer and mask unchanged.
- R8: Registers 8–15 (bits [4:3] = 01, outs) of window w are the same physical registers as registers 24–31 (bits [4:3] = 11, ins) of window w − 1.
- R9: Registers 16–23 (bits [4:3] = 10, locals) are private to each window: writing them in one window does not change them in another.
- R10: A write in the same cycle as a call or return goes to the window that was active before the move.
- R11: Call and return asserted in the same cycle are ignored: no move, no mask change, no flag.
- R12: Reads are combinational; a read of the register being written in the same cycle returns the old value, and the new value is visible after the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 5 | Architectural register number, read port A |
| rd_a_data | output | DW | Read data, port A |
| rd_b_idx | input | 5 | Architectural register number, read port B |
| rd_b_data | output | DW | Read data, port B |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Architectural register number, write port |
| wr_data | input | DW | Write data |
| call_i | input | 1 | Move the window down by one |
| ret_i | input | 1 | Move the window up by one |
| cwp_o | output | log2(NWIN) | Active window index |
| wvalid_o | output | NWIN | Occupancy mask, one bit per window |
| ovf_o | output | 1 | Refused call, one-cycle pulse |
| unf_o | output | 1 | Refused return, one-cycle pulse |

## Verification
A corrupted pointer or mask is visible on cwp_o and wvalid_o at the first negative edge after the offending strobe, and it also shifts every windowed read at once. A bad mask update stays hidden until the ring fills or empties, so the bench walks the full call depth up to an overflow and all the way back down to an underflow. Mapping faults show only when data crosses windows, so values are written in one window and read back in its neighbour through the overlap, the globals and the locals.

// File: rtl/rwin_pkg.sv
package rwin_pkg;

    localparam int ARCH_W = 5;
    localparam int NGLOB  = 8;

    // Register group, decoded from architectural index bits [4:3]
    typedef enum logic [1:0] {
        GRP_GLOBAL = 2'd0,
        GRP_OUT    = 2'd1,
        GRP_LOCAL  = 2'd2,
        GRP_IN     = 2'd3
    } reg_group_e;

    function automatic reg_group_e group_of(input logic [ARCH_W-1:0] idx);
        return reg_group_e'(idx[4:3]);
    endfunction

endpackage

// File: rtl/rwin_map.sv
module rwin_map
    import rwin_pkg::*;
#(
    parameter int NWIN   = 8,
    parameter int CW     = $clog2(NWIN),
    parameter int PHYS_W = 8
) (
    input  logic [ARCH_W-1:0] arch_idx,
    input  logic [CW-1:0]     cwp,
    output logic [PHYS_W-1:0] phys_idx,
    output logic              is_zero
);
    localparam int SLOT_W = CW + 4;

    logic [CW-1:0]     win;
    logic              half;
    logic [SLOT_W-1:0] slot;
    reg_group_e        grp;

    always_comb begin
        grp  = group_of(arch_idx);
        win  = cwp;
        half = 1'b0;
        unique case (grp)
            GRP_GLOBAL: half = 1'b0;
            GRP_OUT:    half = 1'b1;
            GRP_LOCAL:  half = 1'b0;
            GRP_IN: begin
                win  = cwp + 1'b1;
                half = 1'b1;
            end
        endcase
        slot = {win, half, arch_idx[2:0]};
        if (grp == GRP_GLOBAL) begin
            phys_idx = PHYS_W'(arch_idx[2:0]);
        end else begin
            phys_idx = PHYS_W'(NGLOB) + PHYS_W'(slot);
        end
    end

    assign is_zero = (arch_idx == '0);

endmodule

// File: rtl/rwin_ctrl.sv
module rwin_ctrl #(
    parameter int NWIN = 8,
    parameter int CW   = $clog2(NWIN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            call_i,
    input  logic            ret_i,
    output logic [CW-1:0]   cwp,
    output logic [NWIN-1:0] mask,
    output logic            ovf,
    output logic            unf
);
    typedef struct packed {
        logic [CW-1:0]   cwp;
        logic [NWIN-1:0] mask;
        logic            ovf;
        logic            unf;
    } ctrl_state_t;

    localparam ctrl_state_t RESET_STATE = '{
        cwp:  '0,
        mask: NWIN'(1),
        ovf:  1'b0,
        unf:  1'b0
    };

    ctrl_state_t st_d, st_q;
    logic [CW-1:0] win_dn, win_up;

    always_comb begin
        st_d     = st_q;
        st_d.ovf = 1'b0;
        st_d.unf = 1'b0;
        win_dn   = st_q.cwp - 1'b1;
        win_up   = st_q.cwp + 1'b1;
        if (call_i && !ret_i) begin
            if (st_q.mask[win_dn]) begin
                st_d.ovf = 1'b1;
            end else begin
                st_d.cwp          = win_dn;
                st_d.mask[win_dn] = 1'b1;
            end
        end else if (ret_i && !call_i) begin
            if (!st_q.mask[win_up]) begin
                st_d.unf = 1'b1;
            end else begin
                st_d.mask[st_q.cwp] = 1'b0;
                st_d.cwp            = win_up;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_STATE;
        else        st_q <= st_d;
    end

    assign cwp  = st_q.cwp;
    assign mask = st_q.mask;
    assign ovf  = st_q.ovf;
    assign unf  = st_q.unf;

endmodule

// File: rtl/rwin_store.sv
module rwin_store #(
    parameter int DW     = 32,
    parameter int NPHYS  = 136,
    parameter int PHYS_W = $clog2(NPHYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PHYS_W-1:0] wr_phys,
    input  logic [DW-1:0]     wr_data,
    input  logic [PHYS_W-1:0] rd_a_phys,
    input  logic [PHYS_W-1:0] rd_b_phys,
    output logic [DW-1:0]     rd_a_word,
    output logic [DW-1:0]     rd_b_word
);
    logic [DW-1:0] mem_d [NPHYS];
    logic [DW-1:0] mem_q [NPHYS];

    always_comb begin
        for (int i = 0; i < NPHYS; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en && (int'(wr_phys) < NPHYS)) begin
            mem_d[wr_phys] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NPHYS; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < NPHYS; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rd_a_word = (int'(rd_a_phys) < NPHYS) ? mem_q[rd_a_phys] : '0;
    assign rd_b_word = (int'(rd_b_phys) < NPHYS) ? mem_q[rd_b_phys] : '0;

endmodule

// File: rtl/rwin_regfile.sv
module rwin_regfile
    import rwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int DW   = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [4:0]              rd_a_idx,
    output logic [DW-1:0]           rd_a_data,
    input  logic [4:0]              rd_b_idx,
    output logic [DW-1:0]           rd_b_data,
    input  logic                    wr_en,
    input  logic [4:0]              wr_idx,
    input  logic [DW-1:0]           wr_data,
    input  logic                    call_i,
    input  logic                    ret_i,
    output logic [$clog2(NWIN)-1:0] cwp_o,
    output logic [NWIN-1:0]         wvalid_o,
    output logic                    ovf_o,
    output logic                    unf_o
);
    localparam int CW     = $clog2(NWIN);
    localparam int NPHYS  = NGLOB + NWIN * 2 * NGLOB;
    localparam int PHYS_W = $clog2(NPHYS);
    localparam int NPORT  = 3;   // 0: read A, 1: read B, 2: write

    logic [CW-1:0]     cwp;
    logic [ARCH_W-1:0] port_idx  [NPORT];
    logic [PHYS_W-1:0] port_phys [NPORT];
    logic              port_zero [NPORT];
    logic [DW-1:0]     word_a, word_b;

    assign port_idx[0] = rd_a_idx;
    assign port_idx[1] = rd_b_idx;
    assign port_idx[2] = wr_idx;

    rwin_ctrl #(.NWIN(NWIN), .CW(CW)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .call_i (call_i),
        .ret_i  (ret_i),
        .cwp    (cwp),
        .mask   (wvalid_o),
        .ovf    (ovf_o),
        .unf    (unf_o)
    );

    for (genvar g = 0; g < NPORT; g++) begin : g_map
        rwin_map #(.NWIN(NWIN), .CW(CW), .PHYS_W(PHYS_W)) u_map (
            .arch_idx (port_idx[g]),
            .cwp      (cwp),
            .phys_idx (port_phys[g]),
            .is_zero  (port_zero[g])
        );
    end

    rwin_store #(.DW(DW), .NPHYS(NPHYS), .PHYS_W(PHYS_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en && !port_zero[2]),
        .wr_phys   (port_phys[2]),
        .wr_data   (wr_data),
        .rd_a_phys (port_phys[0]),
        .rd_b_phys (port_phys[1]),
        .rd_a_word (word_a),
        .rd_b_word (word_b)
    );

    assign rd_a_data = port_zero[0] ? '0 : word_a;
    assign rd_b_data = port_zero[1] ? '0 : word_b;
    assign cwp_o     = cwp;

endmodule

// File: rtl/rwin_regfile_chk.sv
module rwin_regfile_chk #(
    parameter int NWIN = 8,
    parameter int DW   = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [4:0]              rd_a_idx,
    input logic [DW-1:0]           rd_a_data,
    input logic [4:0]              rd_b_idx,
    input logic [DW-1:0]           rd_b_data,
    input logic                    call_i,
    input logic                    ret_i,
    input logic [$clog2(NWIN)-1:0] cwp_o,
    input logic [NWIN-1:0]         wvalid_o,
    input logic                    ovf_o,
    input logic                    unf_o
);
    localparam int CW = $clog2(NWIN);

    logic [CW-1:0] nb_dn, nb_up;
    assign nb_dn = cwp_o - 1'b1;
    assign nb_up = cwp_o + 1'b1;

    // R1
    active_window_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wvalid_o[cwp_o]);

    // R2
    zero_reg_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == 5'd0) |-> (rd_a_data == '0));

    // R2
    zero_reg_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_idx == 5'd0) |-> (rd_b_data == '0));

    // R4
    call_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !ret_i && !wvalid_o[nb_dn]) |=>
            (cwp_o == $past(nb_dn)) && wvalid_o[cwp_o] && !ovf_o);

    // R5
    ret_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !call_i && wvalid_o[nb_up]) |=>
            (cwp_o == $past(nb_up)) && !wvalid_o[$past(cwp_o)] && !unf_o);

    // R6
    no_overflow_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !ret_i && wvalid_o[nb_dn]) |=>
            ovf_o && $stable(cwp_o) && $stable(wvalid_o));

    // R7
    no_underflow_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !call_i && !wvalid_o[nb_up]) |=>
            unf_o && $stable(cwp_o) && $stable(wvalid_o));

    // R11
    both_strobes_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i == ret_i) |=>
            !ovf_o && !unf_o && $stable(cwp_o) && $stable(wvalid_o));

    // R6
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_o && unf_o));

endmodule

bind rwin_regfile rwin_regfile_chk #(.NWIN(NWIN), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_a_idx  (rd_a_idx),
    .rd_a_data (rd_a_data),
    .rd_b_idx  (rd_b_idx),
    .rd_b_data (rd_b_data),
    .call_i    (call_i),
    .ret_i     (ret_i),
    .cwp_o     (cwp_o),
    .wvalid_o  (wvalid_o),
    .ovf_o     (ovf_o),
    .unf_o     (unf_o)
);

// File: tb/rwin_regfile_bench.sv
module rwin_regfile_bench;
    localparam int NWIN = 8;
    localparam int DW   = 32;
    localparam int NVEC = 18;

    // {op[1:0], cwp[2:0], mask[7:0], ovf, unf}; op 0 idle, 1 call, 2 return, 3 both
    localparam logic [14:0] VEC [NVEC] = '{
        {2'd2, 3'd0, 8'h01, 1'b0, 1'b1},
        {2'd1, 3'd7, 8'h81, 1'b0, 1'b0},
        {2'd1, 3'd6, 8'hC1, 1'b0, 1'b0},
        {2'd1, 3'd5, 8'hE1, 1'b0, 1'b0},
        {2'd1, 3'd4, 8'hF1, 1'b0, 1'b0},
        {2'd1, 3'd3, 8'hF9, 1'b0, 1'b0},
        {2'd1, 3'd2, 8'hFD, 1'b0, 1'b0},
        {2'd1, 3'd1, 8'hFF, 1'b0, 1'b0},
        {2'd1, 3'd1, 8'hFF, 1'b1, 1'b0},
        {2'd3, 3'd1, 8'hFF, 1'b0, 1'b0},
        {2'd2, 3'd2, 8'hFD, 1'b0, 1'b0},
        {2'd2, 3'd3, 8'hF9, 1'b0, 1'b0},
        {2'd2, 3'd4, 8'hF1, 1'b0, 1'b0},
        {2'd2, 3'd5, 8'hE1, 1'b0, 1'b0},
        {2'd2, 3'd6, 8'hC1, 1'b0, 1'b0},
        {2'd2, 3'd7, 8'h81, 1'b0, 1'b0},
        {2'd2, 3'd0, 8'h01, 1'b0, 1'b0},
        {2'd2, 3'd0, 8'h01, 1'b0, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [DW-1:0] rd_a_data, rd_b_data, wr_data = '0;
    logic          wr_en = 1'b0, call_i = 1'b0, ret_i = 1'b0;
    logic [2:0]    cwp_o;
    logic [7:0]    wvalid_o;
    logic          ovf_o, unf_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    rwin_regfile #(.NWIN(NWIN), .DW(DW)) u_rwin_regfile (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .call_i(call_i), .ret_i(ret_i),
        .cwp_o(cwp_o), .wvalid_o(wvalid_o), .ovf_o(ovf_o), .unf_o(unf_o)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] idx, input logic [31:0] val);
        wr_en = 1'b1; wr_idx = idx; wr_data = val;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [4:0] idx, input logic [31:0] exp);
        rd_a_idx = idx; rd_b_idx = idx;
        #1;
        chk(tag, "read A", rd_a_data, exp);
        chk(tag, "read B", rd_b_data, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1", "cwp", 32'(cwp_o), 32'd0);
        chk("R1", "mask", 32'(wvalid_o), 32'h01);
        chk("R1", "ovf", 32'(ovf_o), 32'd0);
        chk("R1", "unf", 32'(unf_o), 32'd0);
        for (int r = 0; r < 32; r++) rd("R1", 5'(r), 32'd0);

        // Window movement table: R4, R5, R6, R7, R11
        for (int v = 0; v < NVEC; v++) begin
            string tag;
            logic [1:0] op;
            op     = VEC[v][14:13];
            call_i = op[0];
            ret_i  = op[1];
            if (op == 2'd3)      tag = "R11";
            else if (VEC[v][1])  tag = "R6";
            else if (VEC[v][0])  tag = "R7";
            else if (op == 2'd1) tag = "R4";
            else                 tag = "R5";
            step();
            call_i = 1'b0; ret_i = 1'b0;
            chk(tag, "cwp", 32'(cwp_o), 32'(VEC[v][12:10]));
            chk(tag, "mask", 32'(wvalid_o), 32'(VEC[v][9:2]));
            chk(tag, "ovf", 32'(ovf_o), 32'(VEC[v][1]));
            chk(tag, "unf", 32'(unf_o), 32'(VEC[v][0]));
        end

        // R6/R7 flags last one cycle only
        step();
        chk("R7", "unf pulse width", 32'(unf_o), 32'd0);

        // R2: writes to register 0 are dropped
        wr(5'd0, 32'hDEAD_BEEF);
        rd("R2", 5'd0, 32'd0);

        // Setup in window 0: global, out, local
        wr(5'd5,  32'h0000_0055);
        wr(5'd9,  32'h0000_0099);
        wr(5'd17, 32'h0000_0170);
        call_i = 1'b1; step(); call_i = 1'b0;
        chk("R4", "cwp after call", 32'(cwp_o), 32'd7);
        rd("R3", 5'd5,  32'h0000_0055);
        rd("R8", 5'd25, 32'h0000_0099);
        rd("R9", 5'd17, 32'd0);
        wr(5'd17, 32'h0000_0177);

        // R8: callee writes result into its ins, caller sees it in its outs
        wr(5'd26, 32'h0000_0AAA);

        // R10: write together with return goes to window 7
        ret_i = 1'b1; wr_en = 1'b1; wr_idx = 5'd16; wr_data = 32'h0000_A0A0;
        step();
        ret_i = 1'b0; wr_en = 1'b0;
        chk("R5", "cwp after return", 32'(cwp_o), 32'd0);
        rd("R10", 5'd16, 32'd0);
        rd("R9",  5'd17, 32'h0000_0170);
        rd("R8",  5'd10, 32'h0000_0AAA);
        rd("R3",  5'd5,  32'h0000_0055);

        call_i = 1'b1; step(); call_i = 1'b0;
        rd("R10", 5'd16, 32'h0000_A0A0);
        rd("R9",  5'd17, 32'h0000_0177);

        // R12: same-cycle read returns old value, new value after the edge
        wr_en = 1'b1; wr_idx = 5'd20; wr_data = 32'h0000_1234;
        rd("R12", 5'd20, 32'd0);
        step();
        wr_en = 1'b0;
        rd("R12", 5'd20, 32'h0000_1234);

        finish_run();
    end

endmodule